// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block connects an A port and a B port with two independent 18-bit storage paths, one for each direction. Each path has a latch-enable, a bus clock and an output enable. While latch-enable is high, the path is transparent and the output follows the input. While latch-enable is low, the path holds its stored word. It takes a new word only on a falling edge of its bus clock.

The block runs on a fast system clock. It samples each bus clock and detects the high-to-low transition on that clock. Each port appears as an output data vector plus a drive-enable instead of a tri-state bus. A simulation wrapper can merge these with the input vector. The A-to-B output enable is active high and the B-to-A output enable is active low. Disabling an output turns off only the drive; storage keeps working.

Top module: `ubus_xcvr`

## Requirements
- R1: Both paths are W bits wide (default 18) and work independently of each other.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle (transparent).
- R3: When `ab_le` goes from 1 to 0 and no bus-clock fall occurs, `b_out` holds the last `a_in` sampled at a system clock edge while `ab_le` was 1, even if `a_in` then changes.
- R4: While `ab_le` is 0 and `ab_clk` stays at a steady level, `b_out` does not change.
- R5: While `ab_le` is 0, a 1-to-0 transition of `ab_clk` seen at a system clock edge stores `a_in` from that edge. From the next cycle on, `b_out` shows that value.
- R6: A 0-to-1 transition of `ab_clk` stores nothing.
- R7: `b_drive` is 1 exactly when `ab_oe` is 1 (active high).
- R8: `a_drive` is 1 exactly when `ba_oe_n` is 0 (active low).
- R9: Storage loads and holds as usual while the output drive is off. The stored word appears once drive returns.
- R10: After reset both stored words are 0, so with latch-enables low both outputs read 0.
- R11: The B-to-A path follows R2 to R6 using `b_in`, `ba_le`, `ba_clk` and `a_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | W | Data received on the A port |
| b_in | input | W | Data received on the B port |
| ab_le | input | 1 | A-to-B latch-enable |
| ab_clk | input | 1 | A-to-B bus clock, captures on its falling edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch-enable |
| ba_clk | input | 1 | B-to-A bus clock, captures on its falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | W | Data to drive onto the A port |
| a_drive | output | 1 | Drive-enable for the A port |
| b_out | output | W | Data to drive onto the B port |
| b_drive | output | 1 | Drive-enable for the B port |

## Verification
Transparent data and both drive-enables are combinational, so the bench checks them in the same cycle it drives the inputs, after a short settle delay. A bus-clock fall is seen at the next system clock edge, and the stored word appears on the output right after that edge. Capture and latch results are therefore checked one cycle after the stimulus, at the falling system-clock edge. Before each such check the bench changes the data input, so a transparent leak would show as a mismatch.

// File: rtl/ubus_xcvr.sv
module ubus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic [W-1:0] b_out,
  output logic         b_drive
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_ck_d, ba_ck_d;
  logic         ab_fall, ba_fall;

  assign ab_fall = ab_ck_d & ~ab_clk;
  assign ba_fall = ba_ck_d & ~ba_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_ck_d <= 1'b0;
      ba_ck_d <= 1'b0;
    end else begin
      ab_ck_d <= ab_clk;
      ba_ck_d <= ba_clk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 ab_q <= '0;
    else if (ab_le || ab_fall)  ab_q <= a_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 ba_q <= '0;
    else if (ba_le || ba_fall)  ba_q <= b_in;
  end

  assign b_out   = ab_le ? a_in : ab_q;
  assign a_out   = ba_le ? b_in : ba_q;
  assign b_drive = ab_oe;
  assign a_drive = ~ba_oe_n;

endmodule

module ubus_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_oe_n,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b_out,
  input logic         b_drive
);

  logic seen1, seen2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  // R4
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen2 && !ab_le && $past(!ab_le) && !($past(ab_clk, 2) && !$past(ab_clk)))
      |-> $stable(b_out));

  // R5
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen2 && !ab_le && $past(!ab_le) && $past(ab_clk, 2) && !$past(ab_clk))
      |-> b_out == $past(a_in));

  // R3
  ab_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && !ab_le && $past(ab_le)) |-> b_out == $past(a_in));

  // R11
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen2 && !ba_le && $past(!ba_le) && !($past(ba_clk, 2) && !$past(ba_clk)))
      |-> $stable(a_out));

  // R11
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen2 && !ba_le && $past(!ba_le) && $past(ba_clk, 2) && !$past(ba_clk))
      |-> a_out == $past(b_in));

  // R2
  ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> b_out == a_in);

endmodule

bind ubus_xcvr ubus_xcvr_chk #(.W(W)) chk (.*);

// File: tb/ubus_xcvr_test.sv
module ubus_xcvr_test;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
  logic ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ubus_xcvr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
  );

  function automatic logic [W-1:0] pat(input int k, input int salt);
    logic [W-1:0] v;
    v = W'((k * 32'h2A5B3 + salt * 32'h1357) ^ (k << 9) ^ (salt << 3));
    return v & MASK;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input bit dir, input logic [W-1:0] v);
    if (dir) b_in = v; else a_in = v;
  endtask
  task automatic set_le(input bit dir, input logic v);
    if (dir) ba_le = v; else ab_le = v;
  endtask
  task automatic set_ck(input bit dir, input logic v);
    if (dir) ba_clk = v; else ab_clk = v;
  endtask
  function automatic logic [W-1:0] out_of(input bit dir);
    return dir ? a_out : b_out;
  endfunction

  task automatic run_dir(input bit dir, input int k);
    logic [W-1:0] v1, v2, v3, v4, other;
    string tag;
    tag = dir ? "R11" : "R1";
    v1 = pat(k, 1); v2 = pat(k, 2) ^ 18'h15555; v3 = pat(k, 3) ^ 18'h2AAAA; v4 = ~v3 & MASK;
    other = out_of(!dir);
    // R2 transparent
    set_le(dir, 1'b1); set_in(dir, v1); #1;
    chk(dir ? "R11 transparent" : "R2 transparent", out_of(dir), v1);
    step();
    // R3 latch on le fall
    set_le(dir, 1'b0); step();
    set_in(dir, v2); #1;
    chk(dir ? "R11 latch" : "R3 latch", out_of(dir), v1);
    // R6 rising edge ignored
    set_ck(dir, 1'b1); step(); #1;
    chk(dir ? "R11 rise" : "R6 rise ignored", out_of(dir), v1);
    // R4 steady high clock
    step(); step(); #1;
    chk(dir ? "R11 hold" : "R4 hold", out_of(dir), v1);
    // R7/R8/R9 drive off during capture on odd k
    if (k % 2 == 1) begin
      if (dir) ba_oe_n = 1'b1; else ab_oe = 1'b0;
      #1;
      chk(dir ? "R8 drive off" : "R7 drive off", W'(dir ? a_drive : b_drive), '0);
    end
    // R5 capture on fall
    set_in(dir, v3); set_ck(dir, 1'b0); step();
    set_in(dir, v4); #1;
    if (k % 2 == 1) begin
      if (dir) ba_oe_n = 1'b0; else ab_oe = 1'b1;
      #1;
      chk(dir ? "R8 drive on" : "R7 drive on", W'(dir ? a_drive : b_drive), 1);
      chk("R9 store while off", out_of(dir), v3);
    end else begin
      chk(dir ? "R11 capture" : "R5 capture", out_of(dir), v3);
    end
    // R4 steady low clock
    step(); step(); #1;
    chk(dir ? "R11 hold low" : "R4 hold low", out_of(dir), v3);
    // R1 other direction untouched
    chk("R1 independent", out_of(!dir), other);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step(); #1;
    chk("R10 reset b_out", b_out, '0);
    chk("R10 reset a_out", a_out, '0);
    chk("R7 b_drive off", W'(b_drive), '0);
    chk("R8 a_drive off", W'(a_drive), '0);
    ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
    chk("R7 b_drive on", W'(b_drive), 1);
    chk("R8 a_drive on", W'(a_drive), 1);
    for (int k = 0; k < 24; k++) begin
      run_dir(1'b0, k);
      run_dir(1'b1, k);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule